// File: doc/BRIEF.md
# Two-level powered min-priority queue

This block is a min-priority queue that keeps a large number of keys while its comparison logic stays small. Incoming keys always land in one of two small sorted register queues. When the queue taking inserts reaches its capacity, the two swap roles. The full one is copied, one key per cycle, into an on-chip RAM slot as a sorted run. Its smallest key, tagged with the slot number and a read position, goes into a small exit queue that holds only the head of each live run.

The minimum of the whole structure is the smaller of the active input queue's head and the exit queue's head. When the two are equal, the input side is served first. When a head is taken from the exit queue, the next key of the same run replaces it. During a copy that key is read straight from the queue being copied, so the copy never stalls a command. When the last key of a run leaves, its slot goes back to the free pool. A smaller unsigned key value means a higher priority.

One command is accepted per cycle while `ready_o` is high. The command encoding on `cmd_i` is 0 insert, 1 get-min (remove and return), 2 delete (remove only) and 3 peek (return only).

Top module: `pq_powered`

## Requirements
- R1: A get-min (cmd_i = 1) on a non-empty queue raises rsp_valid_o for one cycle, in the cycle after it is accepted. rsp_key_o then carries the smallest key held, compared unsigned, and that key is removed.
- R2: A peek (cmd_i = 3) on a non-empty queue returns the smallest key in the same way as a get-min and removes nothing. Repeated peeks give the same key, and a following get-min gives it too.
- R3: A delete (cmd_i = 2) on a non-empty queue removes the smallest key and raises neither rsp_valid_o nor err_o. The next get-min returns the following key in order.
- R4: A get-min, delete or peek on an empty queue raises err_o for exactly one cycle, in the cycle after it is accepted. rsp_valid_o stays low, empty_o stays high and no key is created.
- R5: Inserts (cmd_i = 0) issued on consecutive cycles are all accepted with ready_o high, including across every swap of the input queues.
- R6: full_o is high exactly when the active input queue holds K-1 keys and all L run slots are in use. With the defaults this happens after 35 (L*K+K-1) inserts with no removals. An insert while full_o is high is ignored.
- R7: A run slot is released when its last key is removed. After a full queue is emptied, full_o is low and the full capacity can be inserted again.
- R8: After reset, empty_o is 1, full_o is 0, ready_o is 1, and rsp_valid_o and err_o are 0. empty_o is high exactly when no key is held.
- R9: Duplicate keys are all kept, and each copy is returned by its own get-min.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_i | input | 2 | 0 insert, 1 get-min, 2 delete, 3 peek |
| key_i | input | W | Key to insert |
| ready_o | output | 1 | A command can be accepted |
| full_o | output | 1 | An insert would be refused |
| empty_o | output | 1 | No key is held |
| rsp_valid_o | output | 1 | rsp_key_o is valid (one cycle after get-min or peek) |
| rsp_key_o | output | W | Returned minimum key |
| err_o | output | 1 | Get-min, delete or peek was issued on an empty queue |

## Verification
On every cycle, the assertions check that each base queue stays sorted and never overflows. They also check that the exit queue holds exactly one head per allocated run slot, that ready_o drops only while a copy is in flight, and that refused inserts leave the queue contents alone. Only the bench's scenarios can show the order of keys returned when the minimum moves between the input side and a RAM run, successor fetches while a run is still being copied, and the refill after slots have been released. The bench compares every response against a sorted reference list.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [1:0] {
    CMD_INSERT = 2'd0,
    CMD_GETMIN = 2'd1,
    CMD_DELETE = 2'd2,
    CMD_PEEK   = 2'd3
  } pq_cmd_e;
endpackage

// File: rtl/pq_base_queue.sv
// Sorted register queue: entry 0 is the smallest; pop and push may share a cycle.
module pq_base_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  parameter int KW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic                          pop_i,
  input  logic                          flush_i,
  input  logic [DW-1:0]                 din_i,
  output logic [DEPTH-1:0][DW-1:0]      q_o,
  output logic [CW-1:0]                 cnt_o
);
  logic [DEPTH-1:0][DW-1:0] b, c;
  logic [CW-1:0] nb, nc;
  int pos;

  always_comb begin
    b  = q_o;
    nb = cnt_o;
    if (pop_i && cnt_o != '0) begin
      for (int i = 0; i < DEPTH; i++) b[i] = q_o[(i < DEPTH-1) ? i+1 : i];
      nb = cnt_o - CW'(1);
    end
    pos = 0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < nb && b[i][DW-1 -: KW] <= din_i[DW-1 -: KW]) pos = i + 1;
    c  = b;
    nc = nb;
    if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i < pos)       c[i] = b[i];
        else if (i == pos) c[i] = din_i;
        else               c[i] = b[(i > 0) ? i-1 : 0];
      end
      nc = nb + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      cnt_o <= '0;
    end else if (flush_i) begin
      q_o   <= '0;
      cnt_o <= '0;
    end else begin
      q_o   <= c;
      cnt_o <= nc;
    end
  end

  for (genvar g = 0; g < DEPTH-1; g++) begin : g_chk
    a_r1_sorted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o > CW'(g+1)) |-> (q_o[g][DW-1 -: KW] <= q_o[g+1][DW-1 -: KW]));
  end
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i) |-> (cnt_o < CW'(DEPTH)));
endmodule

// File: rtl/pq_slot_pick.sv
// Lowest-index free slot.
module pq_slot_pick #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  free_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N-1; i >= 0; i--)
      if (free_i[i]) idx_o = IW'(i);
    any_o = |free_i;
  end
endmodule

// File: rtl/pq_powered.sv
module pq_powered
  import pq_pkg::*;
#(
  parameter int W = 16,
  parameter int K = 4,
  parameter int L = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_valid_i,
  input  logic [1:0]   cmd_i,
  input  logic [W-1:0] key_i,
  output logic         ready_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         rsp_valid_o,
  output logic [W-1:0] rsp_key_o,
  output logic         err_o
);
  localparam int SW  = (L > 1) ? $clog2(L) : 1;
  localparam int PW  = (K > 1) ? $clog2(K) : 1;
  localparam int EW  = W + SW + PW;
  localparam int ICW = $clog2(K + 1);
  localparam int ECW = $clog2(L + 1);
  localparam int AW  = $clog2(L * K);

  // input side: two sorted queues swapping roles
  logic [K-1:0][W-1:0] in_q [2];
  logic [ICW-1:0]      in_cnt [2];
  logic [1:0]          in_push, in_pop, in_flush;
  logic                act;

  for (genvar g = 0; g < 2; g++) begin : g_in
    pq_base_queue #(.DEPTH(K), .DW(W), .KW(W)) u_q (
      .clk_i, .rst_ni,
      .push_i(in_push[g]), .pop_i(in_pop[g]), .flush_i(in_flush[g]),
      .din_i(key_i), .q_o(in_q[g]), .cnt_o(in_cnt[g]));
  end

  // exit side: one head per live run, {key, slot, index}
  logic [L-1:0][EW-1:0] ex_q;
  logic [ECW-1:0]       ex_cnt;
  logic                 ex_push, ex_pop;
  logic [EW-1:0]        ex_din;

  pq_base_queue #(.DEPTH(L), .DW(EW), .KW(W)) u_exit (
    .clk_i, .rst_ni, .push_i(ex_push), .pop_i(ex_pop), .flush_i(1'b0),
    .din_i(ex_din), .q_o(ex_q), .cnt_o(ex_cnt));

  logic [W-1:0]  ram [L*K];
  logic [L-1:0]  free_q;
  logic          draining;
  logic [PW-1:0] drain_idx;
  logic [SW-1:0] drain_slot;
  logic [SW-1:0] new_slot;
  logic          any_free;

  pq_slot_pick #(.N(L)) u_pick (.free_i(free_q), .idx_o(new_slot), .any_o(any_free));

  logic [K-1:0][W-1:0] act_q, dq;
  logic [ICW-1:0] act_cnt;
  logic [W-1:0]   in_key, ex_key, head, succ_key;
  logic [SW-1:0]  ex_slot;
  logic [PW-1:0]  ex_ptr, nxt_ptr;
  logic in_v, ex_v, use_in, accept, is_ins, rm_hit, do_ins, fill_evt, has_succ, drain_last;

  always_comb begin
    act_q    = in_q[act];
    dq       = in_q[~act];
    act_cnt  = in_cnt[act];
    in_key   = act_q[0];
    ex_key   = ex_q[0][EW-1 -: W];
    ex_slot  = ex_q[0][PW +: SW];
    ex_ptr   = ex_q[0][PW-1:0];
    nxt_ptr  = ex_ptr + PW'(1);
    has_succ = ex_ptr != PW'(K-1);
    in_v     = act_cnt != '0;
    ex_v     = ex_cnt != '0;
    use_in   = in_v && (!ex_v || in_key <= ex_key);
    empty_o  = !in_v && !ex_v;
    full_o   = (act_cnt == ICW'(K-1)) && !any_free;
    ready_o  = !(draining && drain_idx != PW'(K-1) && act_cnt == ICW'(K-1));
    accept   = cmd_valid_i && ready_o;
    is_ins   = cmd_i == CMD_INSERT;
    rm_hit   = accept && !empty_o && (cmd_i == CMD_GETMIN || cmd_i == CMD_DELETE);
    do_ins   = accept && is_ins && !full_o;
    fill_evt = do_ins && act_cnt == ICW'(K-1);
    drain_last = draining && drain_idx == PW'(K-1);
    head     = (key_i < act_q[0]) ? key_i : act_q[0];
    // a run still being copied is read straight from its source queue
    if (draining && ex_slot == drain_slot) succ_key = dq[nxt_ptr];
    else succ_key = ram[AW'(ex_slot) * AW'(K) + AW'(nxt_ptr)];

    in_push = '0;  in_push[act]   = do_ins;
    in_pop  = '0;  in_pop[act]    = rm_hit && use_in;
    in_flush = '0; in_flush[~act] = drain_last;
    ex_pop  = rm_hit && !use_in;
    ex_push = fill_evt || (ex_pop && has_succ);
    ex_din  = fill_evt ? {head, new_slot, PW'(0)} : {succ_key, ex_slot, nxt_ptr};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act        <= 1'b0;
      draining   <= 1'b0;
      drain_idx  <= '0;
      drain_slot <= '0;
      free_q     <= '1;
    end else begin
      if (draining) drain_idx <= drain_idx + PW'(1);
      if (drain_last) draining <= 1'b0;
      if (ex_pop && !has_succ) free_q[ex_slot] <= 1'b1;
      if (fill_evt) begin
        act              <= ~act;
        draining         <= 1'b1;
        drain_idx        <= '0;
        drain_slot       <= new_slot;
        free_q[new_slot] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i)
    if (draining) ram[AW'(drain_slot) * AW'(K) + AW'(drain_idx)] <= dq[drain_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_key_o   <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= accept && !empty_o && (cmd_i == CMD_GETMIN || cmd_i == CMD_PEEK);
      rsp_key_o   <= use_in ? in_key : ex_key;
      err_o       <= accept && !is_ins && empty_o;
    end
  end

  a_r7_one_head_per_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ex_cnt) == L - $countones(free_q));
  a_r4_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_ins && empty_o) |=> (err_o && !rsp_valid_o));
  a_r1_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !empty_o && cmd_i == CMD_GETMIN) |=> (rsp_valid_o && !err_o));
  a_r5_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !draining |-> ready_o);
  a_r6_refused_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_ins && full_o) |=> ($stable(act) && $stable(ex_cnt) && $stable(act_cnt)));
endmodule

// File: tb/pq_powered_bench.sv
module pq_powered_bench;
  localparam int W = 16, K = 4, L = 8;
  localparam int CAP = L * K + K - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = '0;
  logic [W-1:0] key = '0;
  logic ready, full, empty, rsp_valid, err;
  logic [W-1:0] rsp_key;

  always #10 clk = ~clk;

  pq_powered #(.W(W), .K(K), .L(L)) u_pq_powered (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .key_i(key),
    .ready_o(ready), .full_o(full), .empty_o(empty),
    .rsp_valid_o(rsp_valid), .rsp_key_o(rsp_key), .err_o(err));

  int checks = 0, failures = 0;
  bit done = 0;
  int mq [0:63];
  int n = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void m_insert(input int k);
    int p = n;
    for (int i = 0; i < n; i++) if (mq[i] > k && p == n) p = i;
    for (int i = n; i > p; i--) mq[i] = mq[i-1];
    mq[p] = k;
    n++;
  endfunction

  function automatic void m_pop();
    for (int i = 0; i < n-1; i++) mq[i] = mq[i+1];
    n--;
  endfunction

  // called at a negedge; returns at the next negedge with the response visible
  task automatic op(input int c, input int k, input string req);
    bit ins_ok, exp_rsp, exp_err;
    int exp_key;
    chk(ready == 1'b1, "R5", ready, 1);
    ins_ok = 0; exp_rsp = 0; exp_err = 0; exp_key = 0;
    if (c == 0) ins_ok = !full;
    else if (n == 0) exp_err = 1;
    else begin
      exp_key = mq[0];
      exp_rsp = (c == 1 || c == 3);
    end
    cmd_valid = 1'b1; cmd = 2'(c); key = W'(k);
    @(negedge clk);
    if (c == 0 && ins_ok) m_insert(k);
    if ((c == 1 || c == 2) && n > 0) m_pop();
    chk(rsp_valid == exp_rsp, req, rsp_valid, exp_rsp);
    chk(err == exp_err, "R4", err, exp_err);
    if (exp_rsp) chk(rsp_key == W'(exp_key), req, rsp_key, exp_key);
    chk(empty == (n == 0), "R8", empty, n == 0);
  endtask

  task automatic idle();
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(empty == 1'b1, "R8", empty, 1);
    chk(full == 1'b0, "R8", full, 0);
    chk(ready == 1'b1, "R8", ready, 1);
    chk(rsp_valid == 1'b0 && err == 1'b0, "R8", rsp_valid | err, 0);
    // R4 empty commands
    op(3, 0, "R4"); op(1, 0, "R4"); op(2, 0, "R4");
    idle();
    chk(err == 1'b0, "R4 one-cycle pulse", err, 0);
    // R2, R3, R1 directed
    op(0, 40, "R1"); op(0, 12, "R1"); op(0, 25, "R1"); op(0, 7, "R1"); op(0, 30, "R1");
    op(3, 0, "R2"); op(3, 0, "R2");
    op(1, 0, "R2");
    op(2, 0, "R3");
    chk(rsp_valid == 1'b0, "R3", rsp_valid, 0);
    while (n > 0) op(1, 0, "R1");
    // R5 back-to-back inserts across swaps, R9 duplicates
    for (int i = 0; i < 3*K+1; i++) op(0, (i % 3 == 0) ? 9 : 50 - i, "R5");
    while (n > 0) op(1, 0, "R9");
    // R6 fill to capacity
    for (int i = 0; i < CAP; i++) begin
      if (i == CAP - 1) chk(full == 1'b0, "R6 before last", full, 0);
      op(0, (i * 37) % 101, "R6");
    end
    chk(full == 1'b1, "R6 full", full, 1);
    op(0, 1, "R6 refused");
    chk(n == CAP, "R6 model", n, CAP);
    while (n > 0) op(1, 0, "R6");
    op(1, 0, "R6 nothing extra");
    chk(full == 1'b0, "R7", full, 0);
    // R7 refill after release
    for (int i = 0; i < CAP; i++) op(0, 200 - i, "R7");
    chk(full == 1'b1, "R7 refill", full, 1);
    while (n > 0) op(1, 0, "R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 8);
      int k = int'($urandom % 64);
      if (r < 4) op(full ? 3 : 0, k, "R1");
      else if (r < 6) op(1, 0, "R1");
      else if (r == 6) op(2, 0, "R3");
      else op(3, 0, "R2");
      if (($urandom % 5) == 0) idle();
    end
    while (n > 0) op(1, 0, "R1");
    idle();
    finish_run();
  end
endmodule